// File: doc/BRIEF.md
# Symmetric Tanh Activation Lookup

This block returns the hyperbolic tangent of a signed 16-bit fixed-point argument, for use as a neuron activation after a multiply-accumulate stage. Arguments and results are both signed Q3.12, so 1.0 is code 4096. Only the non-negative half of the curve is stored, from 0 up to 3.0. The full function is rebuilt from that half. A negative argument reads the entry for its magnitude and the result is negated. An argument whose magnitude is beyond 3.0 skips the table and returns exactly +1.0 or -1.0.

The table sits in a small RAM. An external controller fills it at power-up through a write port. Lookups are issued with a valid strobe and come back with a valid strobe two cycles later. A new lookup may be issued every cycle. A table write is dropped whenever it would collide with a lookup in progress, so the read path never sees a half-updated entry.

Top module: `tanh_act_lut`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `outResult` is 0 until the first lookup completes.
- R2: `outValid` is high exactly two clock edges after the edge that samples `inValid` high, and never otherwise. Lookups issued on consecutive cycles each produce one result, in issue order.
- R3: For an argument from 0 to 12288 (0.0 to 3.0), the result is table entry `inArg >> 6`.
- R4: For a negative argument from -12288 to -1, the result is the two's-complement negation of table entry `|inArg| >> 6`.
- R5: An argument above 12288 yields 4096 (+1.0).
- R6: An argument below -12288 yields 0xF000 (-1.0). This includes the most negative code 0x8000, which saturates and does not wrap.
- R7: With `ldEn` high, `ldAddr` below 193, and no lookup in progress, `ldData` is written to table entry `ldAddr`. A lookup issued on the next cycle reads the new value.
- R8: A write is ignored when `inValid` is high in the same cycle, or when a lookup was accepted on the previous edge. The entry keeps its old contents.
- R9: `outResult` holds its value in every cycle where no new result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Lookup request strobe |
| inArg | input | 16 | Argument, signed Q3.12 |
| outValid | output | 1 | Result strobe, two cycles after the request |
| outResult | output | 16 | tanh of the argument, signed Q3.12 |
| ldEn | input | 1 | Table write strobe |
| ldAddr | input | 8 | Table entry index, 0 to 192 |
| ldData | input | 16 | Table entry value, Q3.12 |

## Verification
The assertions check on every cycle the properties that hold whatever the table contents are. These are the two-cycle valid timing, the absence of spurious results, clamping to exactly +1.0 or -1.0 for out-of-range arguments, the hold of `outResult`, and that a table write never coincides with a read and lands where it was aimed.

Some behaviour depends on the table contents, so only the bench scenarios can show it. This covers choosing the right entry for an argument, mirroring the stored half for negative arguments, and the ordering of back-to-back results. It also covers that a write dropped during a lookup leaves the old entry readable, while a write made when idle is seen by the very next lookup.

// File: rtl/tanh_lut_pkg.sv
package tanh_lut_pkg;

  // Control strobes handed from the sequencer to the datapath and table.
  typedef struct packed {
    logic memRd;   // read the table at the computed index
    logic memWr;   // commit a load-port write
    logic s1Load;  // capture sign and range flags of a new request
    logic s2Load;  // form the final result
  } tanhStrobes_t;

endpackage

// File: rtl/tanh_half_ram.sv
module tanh_half_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 193,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

  // R8
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !rdEn);

  // R7
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> mem[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/tanh_lut_ctrl.sv
module tanh_lut_ctrl
  import tanh_lut_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 193
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  output tanhStrobes_t      strobes,
  output logic              outValid
);

  logic s1Valid;
  logic lookupBusy;
  logic addrInRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  // A lookup is in progress from the cycle it is offered until its
  // table read has been captured.
  assign lookupBusy  = inValid | s1Valid;
  assign addrInRange = int'(ldAddr) < DEPTH;

  always_comb begin
    strobes        = '0;
    strobes.memRd  = inValid;
    strobes.s1Load = inValid;
    strobes.s2Load = s1Valid;
    strobes.memWr  = ldEn & addrInRange & ~lookupBusy;
  end

endmodule

// File: rtl/tanh_lut_datapath.sv
module tanh_lut_datapath
  import tanh_lut_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAC_W    = 12,
  parameter int IDX_SHIFT = 6,
  parameter int LIMIT     = 12288,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tanhStrobes_t      strobes,
  input  logic [DATA_W-1:0] inArg,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] outResult
);

  localparam logic [DATA_W-1:0] POS_ONE   = DATA_W'(1 << FRAC_W);
  localparam logic [DATA_W-1:0] NEG_ONE   = ~POS_ONE + 1'b1;
  localparam logic [DATA_W:0]   LIMIT_EXT = (DATA_W+1)'(LIMIT);

  logic            argNeg;
  logic [DATA_W:0] argExt;
  logic [DATA_W:0] magExt;
  logic            overRange;
  logic            negQ;
  logic            overQ;
  logic [DATA_W-1:0] nextResult;

  // Magnitude is one bit wider so the most negative code does not wrap.
  assign argNeg    = inArg[DATA_W-1];
  assign argExt    = {inArg[DATA_W-1], inArg};
  assign magExt    = argNeg ? (~argExt + 1'b1) : argExt;
  assign overRange = magExt > LIMIT_EXT;
  assign rdAddr    = overRange ? '0 : ADDR_W'(magExt >> IDX_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negQ  <= 1'b0;
      overQ <= 1'b0;
    end else if (strobes.s1Load) begin
      negQ  <= argNeg;
      overQ <= overRange;
    end
  end

  always_comb begin
    if (overQ)     nextResult = negQ ? NEG_ONE : POS_ONE;
    else if (negQ) nextResult = ~rdData + 1'b1;
    else           nextResult = rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outResult <= '0;
    else if (strobes.s2Load) outResult <= nextResult;
  end

endmodule

// File: rtl/tanh_act_lut.sv
module tanh_act_lut
  import tanh_lut_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAC_W    = 12,
  parameter int RANGE_INT = 3,
  parameter int IDX_SHIFT = 6,
  localparam int LIMIT    = RANGE_INT << FRAC_W,
  localparam int DEPTH    = (LIMIT >> IDX_SHIFT) + 1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inArg,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData
);

  localparam logic [DATA_W-1:0] POS_ONE = DATA_W'(1 << FRAC_W);
  localparam logic [DATA_W-1:0] NEG_ONE = ~POS_ONE + 1'b1;

  tanhStrobes_t      strobes;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;

  tanh_lut_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ldEn(ldEn),
    .ldAddr(ldAddr), .strobes(strobes), .outValid(outValid)
  );

  tanh_lut_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .IDX_SHIFT(IDX_SHIFT),
    .LIMIT(LIMIT), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inArg(inArg),
    .rdAddr(rdAddr), .rdData(rdData), .outResult(outResult)
  );

  tanh_half_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rstN(rstN), .rdEn(strobes.memRd), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(strobes.memWr), .wrAddr(ldAddr), .wrData(ldData)
  );

  // R2
  out_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R5
  pos_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ($signed(inArg) > LIMIT)) |-> ##2 (outResult == POS_ONE));

  // R6
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ($signed(inArg) < -LIMIT)) |-> ##2 (outResult == NEG_ONE));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outResult));

endmodule

// File: tb/tanh_act_lut_tb.sv
module tanh_act_lut_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 193;
  localparam int LIMIT      = 12288;

  typedef struct {
    logic [15:0] val;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] inArg;
  logic        outValid;
  logic [15:0] outResult;
  logic        ldEn;
  logic [7:0]  ldAddr;
  logic [15:0] ldData;

  int testCount = 0;
  int failCount = 0;
  logic [15:0] model [DEPTH];
  expItem_t    expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tanh_act_lut u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inArg(inArg),
    .outValid(outValid), .outResult(outResult),
    .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData)
  );

  task automatic report(string req, logic [15:0] act, logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expFor(logic [15:0] x);
    int sx;
    int mag;
    sx  = int'($signed(x));
    mag = (sx < 0) ? -sx : sx;
    if (mag > LIMIT) return (sx < 0) ? 16'hF000 : 16'h1000;
    return (sx < 0) ? (~model[mag >> 6] + 16'd1) : model[mag >> 6];
  endfunction

  // Driver: offer one lookup in the coming edge and queue its expectation.
  task automatic issue(logic [15:0] x, string req);
    expItem_t it;
    inValid = 1'b1;
    inArg   = x;
    it.val  = expFor(x);
    it.req  = req;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic loadEntry(int a, logic [15:0] d);
    ldEn   = 1'b1;
    ldAddr = 8'(a);
    ldData = d;
    @(negedge clk);
    ldEn   = 1'b0;
  endtask

  // Monitor: compare each produced result against the scoreboard head.
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (expQ.size() == 0) begin
        report("R2 unexpected result", 16'h0001, 16'h0000);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        report(it.req, outResult, it.val);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rstN = 1'b0; inValid = 1'b0; inArg = '0;
    ldEn = 1'b0; ldAddr = '0; ldData = '0;
    repeat (3) @(negedge clk);
    report("R1 outValid in reset", {15'd0, outValid}, 16'd0);
    report("R1 outResult in reset", outResult, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    report("R1 outValid after reset", {15'd0, outValid}, 16'd0);

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'(i * 21 + 7);
      loadEntry(i, model[i]);
    end
    idle(2);

    // R2: single lookup timing
    issue(16'd640, "R3 idx10");
    inValid = 1'b0;
    report("R2 not valid after one edge", {15'd0, outValid}, 16'd0);
    @(negedge clk);
    report("R2 valid after two edges", {15'd0, outValid}, 16'd1);
    idle(3);

    // R3 with back-to-back issue (R2 ordering)
    issue(16'd0,     "R3 zero");
    issue(16'd63,    "R3 below step");
    issue(16'd64,    "R3 one step");
    issue(16'd1000,  "R3 mid");
    issue(16'd12287, "R3 below limit");
    issue(16'd12288, "R3 at limit");
    idle(4);

    // R4 negative mirror
    issue(16'hFFFF, "R4 minus one lsb");
    issue(-16'sd64, "R4 minus step");
    issue(-16'sd5000, "R4 mid");
    issue(-16'sd12288, "R4 at limit");
    idle(4);

    // R5 / R6 saturation
    issue(16'd12289, "R5 just above");
    issue(16'd20000, "R5 mid");
    issue(16'h7FFF,  "R5 max");
    issue(-16'sd12289, "R6 just below");
    issue(-16'sd20000, "R6 mid");
    issue(16'h8000,  "R6 most negative");
    idle(4);

    // R8: writes colliding with a lookup are dropped (model untouched)
    ldEn = 1'b1; ldAddr = 8'd5; ldData = 16'hBEEF;
    issue(16'd320, "R8 same-cycle lookup");
    inValid = 1'b0;
    ldAddr = 8'd6; ldData = 16'hCAFE;
    @(negedge clk);
    ldEn = 1'b0;
    idle(3);
    issue(16'd320, "R8 entry5 unchanged");
    issue(16'd384, "R8 entry6 unchanged");
    idle(4);

    // R7: idle write visible to the next lookup
    loadEntry(5, 16'h0ABC);
    model[5] = 16'h0ABC;
    issue(16'd320,  "R7 new entry");
    issue(-16'sd320, "R7 new entry negated");
    idle(4);

    // R9: result holds while idle
    held = outResult;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      report("R9 result held", outResult, held);
    end

    report("R2 all results returned", 16'(expQ.size()), 16'd0);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule